// File: doc/BRIEF.md
# Bit-Granular Field Access Unit

This block sits between a processor datapath and a word-organised synchronous memory. It lets the processor treat memory as one long string of bits. A request names a field by its starting bit address and its length in bits. The field can begin at any bit and can run across a word boundary. The block turns the request into one or two word reads. For a write or a swap, it then writes back one or two merged words in which only the bits of the field change.

The field's starting address comes from a field-address counter held in the block. A remaining-length counter sits beside it. Both counters can be loaded directly. Any access may ask for the bits it moved to be counted: the address then moves up and the remaining length moves down by the same amount. This lets a sequence of accesses walk along a long bit string without reloading the address.

The processor sees a valid/ready request port and a one-cycle completion strobe. The read field appears right-justified on the result bus in the same cycle as the strobe. The bit order inside the field can be chosen per access.

Top module: `bitfield_access`

## Requirements
- R1: Memory bit `a` is bit `a[4:0]` of word `a[15:5]`. A field of length L starting at the field-address counter value `a` covers memory bits a, a+1, …, a+L-1. With `req_msb_first`=0, result bit i holds memory bit a+i.
- R2: With `req_msb_first`=1, result bit L-1-i holds memory bit a+i. A write or swap in this order stores data bit L-1-i into memory bit a+i.
- R3: The field length is 0 to 24 bits and can differ on every access. A requested length above 24 is treated as 24. Result bits at and above L are zero.
- R4: A write (`req_op`=01) stores the low L data bits into the field, following the bit order of R1/R2. No other memory bit changes, including when the field straddles two words. A read performs no memory write.
- R5: A swap (`req_op`=10) returns the field's previous contents and stores the new data into it within the same request.
- R6: A request of length 0 makes no memory access. It completes on the first cycle after acceptance and returns zero.
- R7: The completion strobe rises the given number of clock edges after the accepting edge (acceptance edge included):
  - 3 for a read inside one word;
  - 4 for a read across two words;
  - 4 for a write or swap inside one word;
  - 6 for a write or swap across two words.
  `req_ready` is low from acceptance until the cycle after completion.
- R8: `done` is high for exactly one cycle. `rd_data` holds its value until the next completion. A write returns zero. Op code 11 behaves as a read.
- R9: When `req_count`=1, the edge that ends the completion cycle adds L to the field-address counter (modulo 2^16) and subtracts L from the remaining-length counter, stopping at zero. When `req_count`=0, both counters keep their values.
- R10: `ctr_load` writes both counters on the next edge. A load takes precedence over a counting update in the same cycle.
- R11: Addresses wrap: a field that passes bit 65535 continues at bit 0, touching word 2047 and then word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_load | input | 1 | Load both counters |
| ctr_addr_in | input | 16 | Value loaded into the field-address counter |
| ctr_left_in | input | 16 | Value loaded into the remaining-length counter |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | 00 read, 01 write, 10 swap, 11 read |
| req_msb_first | input | 1 | Bit order of the field (R2) |
| req_len | input | 5 | Field length in bits |
| req_count | input | 1 | Step the counters by the length |
| req_wdata | input | 24 | Right-justified write data |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 24 | Right-justified field read |
| field_addr | output | 16 | Field-address counter |
| field_left | output | 16 | Remaining-length counter |
| mem_en | output | 1 | Memory word access enable |
| mem_we | output | 1 | Memory word write enable |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid one cycle after the enabled read |

## Verification
Each request's latency is counted in rising edges from the accepting edge:
- 1 for a zero-length field;
- 3 or 4 for a read, depending on whether the field crosses a word;
- 4 or 6 for a write or swap, on the same condition.

The bench computes this figure from the start offset and length, and requires `done` to appear at exactly that count, sampled on falling edges. The result data and the memory accesses are checked in that same cycle. The counters are checked one cycle later, once the step taken on the edge that ends the strobe has settled.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SWAP  = 2'b10,
    OP_ALT   = 2'b11
  } bfa_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RA,
    ST_RB,
    ST_RC,
    ST_WA,
    ST_WB,
    ST_DONE
  } bfa_state_e;
endpackage

// File: rtl/bfa_shifter.sv
// Field extraction and merge over a two-word window.
module bfa_shifter #(
  parameter int WORD_W  = 32,
  parameter int MAX_LEN = 24,
  parameter int OFF_W   = 5,
  parameter int LEN_W   = 5
) (
  input  logic [WORD_W-1:0]   win_lo,
  input  logic [WORD_W-1:0]   win_hi,
  input  logic [OFF_W-1:0]    bit_off,
  input  logic [LEN_W-1:0]    len,
  input  logic                msb_first,
  input  logic [MAX_LEN-1:0]  wdata,
  output logic [MAX_LEN-1:0]  field_out,
  output logic [2*WORD_W-1:0] merged
);
  localparam int WIN_W = 2 * WORD_W;
  localparam logic [MAX_LEN-1:0] ONES = '1;

  logic [WIN_W-1:0]   win;
  logic [WIN_W-1:0]   shifted;
  logic [LEN_W-1:0]   shamt;
  logic [MAX_LEN-1:0] lmask;
  logic [MAX_LEN-1:0] raw;
  logic [MAX_LEN-1:0] rev_raw;
  logic [MAX_LEN-1:0] rev_wd;
  logic [MAX_LEN-1:0] fnew;

  assign win     = {win_hi, win_lo};
  assign shamt   = LEN_W'(MAX_LEN) - len;
  assign lmask   = ONES >> shamt;
  assign shifted = win >> bit_off;
  assign raw     = shifted[MAX_LEN-1:0] & lmask;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_rev
    assign rev_raw[g] = raw[MAX_LEN-1-g];
    assign rev_wd[g]  = wdata[MAX_LEN-1-g];
  end

  assign field_out = msb_first ? (rev_raw >> shamt) : raw;
  assign fnew      = (msb_first ? (rev_wd >> shamt) : wdata) & lmask;
  assign merged    = (win & ~(WIN_W'(lmask) << bit_off)) | (WIN_W'(fnew) << bit_off);
endmodule

// File: rtl/bfa_counters.sv
// Field-address and remaining-length counters.
module bfa_counters #(
  parameter int ADDR_W = 16,
  parameter int LEFT_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEFT_W-1:0] load_left,
  input  logic              step_en,
  input  logic [LEN_W-1:0]  step_len,
  output logic [ADDR_W-1:0] fa,
  output logic [LEFT_W-1:0] fl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fa <= '0;
      fl <= '0;
    end else if (load) begin
      fa <= load_addr;
      fl <= load_left;
    end else if (step_en) begin
      fa <= fa + ADDR_W'(step_len);
      fl <= (fl > LEFT_W'(step_len)) ? fl - LEFT_W'(step_len) : '0;
    end
  end

  AST_LEFT_NONRISING: assert property (@(posedge clk) disable iff (rst)
    !load |=> (fl <= $past(fl))); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> $stable(fa)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (fa == $past(load_addr) && fl == $past(load_left))); // R10
endmodule

// File: rtl/bfa_seq.sv
// Request sequencer and memory word port.
module bfa_seq
  import bfa_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 32,
  parameter int MAX_LEN = 24,
  parameter int OFF_W   = 5,
  parameter int WADDR_W = 11,
  parameter int LEN_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic                req_msb_first,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                req_count,
  input  logic [MAX_LEN-1:0]  req_wdata,
  input  logic [ADDR_W-1:0]   base_addr,
  output logic                mem_en,
  output logic                mem_we,
  output logic [WADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [WORD_W-1:0]   win_lo,
  output logic [WORD_W-1:0]   win_hi,
  output logic [OFF_W-1:0]    off_q,
  output logic [LEN_W-1:0]    len_q,
  output logic                msb_q,
  output logic [MAX_LEN-1:0]  wdata_q,
  input  logic [MAX_LEN-1:0]  field_out,
  input  logic [2*WORD_W-1:0] merged,
  output logic                done,
  output logic [MAX_LEN-1:0]  rd_data,
  output logic                step_en,
  output logic [LEN_W-1:0]    step_len
);
  localparam int SUM_W = OFF_W + LEN_W + 1;

  bfa_state_e           state;
  bfa_op_e              op_q;
  logic                 count_q;
  logic                 span_q;
  logic [WADDR_W-1:0]   word_q;
  logic [WORD_W-1:0]    lo_q;
  logic [WORD_W-1:0]    hi_q;
  logic [MAX_LEN-1:0]   rd_q;
  logic                 accept;
  logic                 is_wr;
  logic [LEN_W-1:0]     len_clamp;
  logic [SUM_W-1:0]     end_pos;
  logic                 span_d;
  logic [WADDR_W-1:0]   word_next;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_wr     = (op_q == OP_WRITE) || (op_q == OP_SWAP);
  assign len_clamp = (req_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : req_len;
  assign end_pos   = SUM_W'(base_addr[OFF_W-1:0]) + SUM_W'(len_clamp);
  assign span_d    = end_pos > SUM_W'(WORD_W);
  assign word_next = word_q + WADDR_W'(1);

  assign win_lo   = (state == ST_RB) ? mem_rdata : lo_q;
  assign win_hi   = (state == ST_RC) ? mem_rdata : hi_q;
  assign done     = (state == ST_DONE);
  assign rd_data  = rd_q;
  assign step_en  = done && count_q;
  assign step_len = len_q;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = word_q;
    mem_wdata = merged[WORD_W-1:0];
    case (state)
      ST_RA: mem_en = 1'b1;
      ST_RB: begin
        mem_en   = span_q;
        mem_addr = word_next;
      end
      ST_WA: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
      end
      ST_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_next;
        mem_wdata = merged[2*WORD_W-1:WORD_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_q    <= OP_READ;
      count_q <= 1'b0;
      span_q  <= 1'b0;
      word_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      msb_q   <= 1'b0;
      wdata_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      rd_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q    <= bfa_op_e'(req_op);
          count_q <= req_count;
          span_q  <= span_d;
          word_q  <= base_addr[ADDR_W-1:OFF_W];
          off_q   <= base_addr[OFF_W-1:0];
          len_q   <= len_clamp;
          msb_q   <= req_msb_first;
          wdata_q <= req_wdata;
          lo_q    <= '0;
          hi_q    <= '0;
          if (len_clamp == '0) begin
            rd_q  <= '0;
            state <= ST_DONE;
          end else begin
            state <= ST_RA;
          end
        end
        ST_RA: state <= ST_RB;
        ST_RB: begin
          lo_q <= mem_rdata;
          if (span_q) begin
            state <= ST_RC;
          end else begin
            rd_q  <= (op_q == OP_WRITE) ? '0 : field_out;
            state <= is_wr ? ST_WA : ST_DONE;
          end
        end
        ST_RC: begin
          hi_q  <= mem_rdata;
          rd_q  <= (op_q == OP_WRITE) ? '0 : field_out;
          state <= is_wr ? ST_WA : ST_DONE;
        end
        ST_WA:   state <= span_q ? ST_WB : ST_DONE;
        ST_WB:   state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R7
  AST_READ_NEVER_WRITES: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> is_wr); // R4
  AST_EMPTY_FIELD_QUICK: assert property (@(posedge clk) disable iff (rst)
    (accept && req_len == '0) |=> (done && !mem_en)); // R6
  AST_SECOND_WORD_ONLY_ON_SPAN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RC || state == ST_WB) |-> span_q); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !accept) |=> $stable(rd_data)); // R8
endmodule

// File: rtl/bitfield_access.sv
module bitfield_access #(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 32,
  parameter int MAX_LEN = 24,
  parameter int LEFT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ctr_load,
  input  logic [ADDR_W-1:0]             ctr_addr_in,
  input  logic [LEFT_W-1:0]             ctr_left_in,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_op,
  input  logic                          req_msb_first,
  input  logic [$clog2(MAX_LEN+1)-1:0]  req_len,
  input  logic                          req_count,
  input  logic [MAX_LEN-1:0]            req_wdata,
  output logic                          done,
  output logic [MAX_LEN-1:0]            rd_data,
  output logic [ADDR_W-1:0]             field_addr,
  output logic [LEFT_W-1:0]             field_left,
  output logic                          mem_en,
  output logic                          mem_we,
  output logic [ADDR_W-$clog2(WORD_W)-1:0] mem_addr,
  output logic [WORD_W-1:0]             mem_wdata,
  input  logic [WORD_W-1:0]             mem_rdata
);
  localparam int OFF_W   = $clog2(WORD_W);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic [WORD_W-1:0]   win_lo;
  logic [WORD_W-1:0]   win_hi;
  logic [OFF_W-1:0]    off_q;
  logic [LEN_W-1:0]    len_q;
  logic                msb_q;
  logic [MAX_LEN-1:0]  wdata_q;
  logic [MAX_LEN-1:0]  field_out;
  logic [2*WORD_W-1:0] merged;
  logic                step_en;
  logic [LEN_W-1:0]    step_len;

  bfa_counters #(.ADDR_W(ADDR_W), .LEFT_W(LEFT_W), .LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_addr(ctr_addr_in),
    .load_left(ctr_left_in), .step_en(step_en), .step_len(step_len),
    .fa(field_addr), .fl(field_left)
  );

  bfa_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_LEN(MAX_LEN),
            .OFF_W(OFF_W), .WADDR_W(WADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_msb_first(req_msb_first), .req_len(req_len),
    .req_count(req_count), .req_wdata(req_wdata), .base_addr(field_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .win_lo(win_lo),
    .win_hi(win_hi), .off_q(off_q), .len_q(len_q), .msb_q(msb_q),
    .wdata_q(wdata_q), .field_out(field_out), .merged(merged),
    .done(done), .rd_data(rd_data), .step_en(step_en), .step_len(step_len)
  );

  bfa_shifter #(.WORD_W(WORD_W), .MAX_LEN(MAX_LEN), .OFF_W(OFF_W),
                .LEN_W(LEN_W)) u_shf (
    .win_lo(win_lo), .win_hi(win_hi), .bit_off(off_q), .len(len_q),
    .msb_first(msb_q), .wdata(wdata_q), .field_out(field_out),
    .merged(merged)
  );
endmodule

// File: tb/bitfield_access_test.sv
`timescale 1ns/1ps
module bitfield_access_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctr_load = 1'b0;
  logic [15:0] ctr_addr_in = '0;
  logic [15:0] ctr_left_in = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic        req_msb_first = 1'b0;
  logic [4:0]  req_len = '0;
  logic        req_count = 1'b0;
  logic [23:0] req_wdata = '0;
  logic        done;
  logic [23:0] rd_data;
  logic [15:0] field_addr;
  logic [15:0] field_left;
  logic        mem_en;
  logic        mem_we;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int en_cnt = 0;
  int we_cnt = 0;

  logic [31:0]    mem_m [0:2047];
  logic [65535:0] ref_bits;

  always #5 clk = ~clk;

  bitfield_access uut (
    .clk(clk), .rst(rst), .ctr_load(ctr_load), .ctr_addr_in(ctr_addr_in),
    .ctr_left_in(ctr_left_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_msb_first(req_msb_first), .req_len(req_len),
    .req_count(req_count), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .field_addr(field_addr), .field_left(field_left),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(int w);
    return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // Behavioural synchronous word memory, read-before-write.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      for (int i = 0; i < 2048; i++) mem_m[i] <= pat(i);
    end else if (mem_en) begin
      en_cnt <= en_cnt + 1;
      if (mem_we) begin
        we_cnt <= we_cnt + 1;
        mem_m[mem_addr] <= mem_wdata;
      end
      mem_rdata <= mem_m[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_read(logic [15:0] a, int len, bit msb);
    logic [23:0] r = '0;
    int l = (len > 24) ? 24 : len;
    for (int i = 0; i < l; i++) begin
      if (msb) r[l-1-i] = ref_bits[a + 16'(i)];
      else     r[i]     = ref_bits[a + 16'(i)];
    end
    return r;
  endfunction

  task automatic ref_write(input logic [15:0] a, input int len, input bit msb, input logic [23:0] d);
    int l = (len > 24) ? 24 : len;
    for (int i = 0; i < l; i++)
      ref_bits[a + 16'(i)] = msb ? d[l-1-i] : d[i];
  endtask

  function automatic int exp_lat(int op, int len, int off);
    int l = (len > 24) ? 24 : len;
    bit span = (off + l) > 32;
    bit rd = (op == 0) || (op == 3);
    if (l == 0) return 1;
    if (rd) return span ? 4 : 3;
    return span ? 6 : 4;
  endfunction

  function automatic int exp_en(int op, int len, int off);
    int l = (len > 24) ? 24 : len;
    bit span = (off + l) > 32;
    bit rd = (op == 0) || (op == 3);
    if (l == 0) return 0;
    if (rd) return span ? 2 : 1;
    return span ? 4 : 2;
  endfunction

  task automatic load_ctr(input logic [15:0] a, input logic [15:0] l);
    ctr_load = 1'b1; ctr_addr_in = a; ctr_left_in = l;
    @(posedge clk); @(negedge clk);
    ctr_load = 1'b0;
  endtask

  task automatic run_op(input int op, input bit msb, input int len, input logic [23:0] wd,
                        input bit cnt, input bit ld_at_done, input logic [15:0] ld_a,
                        input logic [15:0] ld_l, output logic [23:0] rd, output int lat,
                        output int en_n, output int we_n);
    int en0 = en_cnt;
    int we0 = we_cnt;
    req_op = 2'(op); req_msb_first = msb; req_len = 5'(len);
    req_wdata = wd; req_count = cnt; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    rd = rd_data;
    en_n = en_cnt - en0;
    we_n = we_cnt - we0;
    if (ld_at_done) begin
      ctr_load = 1'b1; ctr_addr_in = ld_a; ctr_left_in = ld_l;
    end
    @(posedge clk); @(negedge clk);
    ctr_load = 1'b0;
    chk(done == 1'b0, "R8 strobe one cycle", 64'(done), 64'd0);
  endtask

  task automatic cmp_words(input logic [15:0] a, input string tag);
    int w = int'(a[15:5]);
    for (int d = -1; d <= 2; d++) begin
      int wi = (w + d) & 2047;
      chk(mem_m[wi] == ref_bits[wi*32 +: 32], tag, 64'(mem_m[wi]), 64'(ref_bits[wi*32 +: 32]));
    end
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [23:0] rd, ex;
    logic [15:0] a;
    int lat, en_n, we_n;
    for (int w = 0; w < 2048; w++) ref_bits[w*32 +: 32] = pat(w);
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);

    // Reset state
    chk(req_ready == 1'b1, "R7 ready after reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R8 no strobe after reset", 64'(done), 64'd0);
    chk(rd_data == '0, "R8 result zero after reset", 64'(rd_data), 64'd0);
    chk(field_addr == '0 && field_left == '0, "R9 counters zero after reset", 64'({field_addr, field_left}), 64'd0);
    chk(mem_en == 1'b0, "R6 memory quiet after reset", 64'(mem_en), 64'd0);

    // Read sweep: every start bit, every length, both orders
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 32; o++)
        for (int l = 0; l <= 24; l++) begin
          a = 16'(((o*37 + l*11 + m*5) % 2048) * 32 + o);
          load_ctr(a, 16'd100);
          ex = ref_read(a, l, m[0]);
          run_op(0, m[0], l, 24'h0, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
          chk(rd == ex, m ? "R2 msb-first read" : "R1 lsb-first read", 64'(rd), 64'(ex));
          chk(lat == exp_lat(0, l, o), "R7 read latency", 64'(lat), 64'(exp_lat(0, l, o)));
          chk(en_n == exp_en(0, l, o) && we_n == 0, l == 0 ? "R6 empty field no access" : "R4 read word accesses",
              64'(en_n * 16 + we_n), 64'(exp_en(0, l, o) * 16));
          chk(field_addr == a && field_left == 16'd100, "R9 counters hold without count",
              64'({field_addr, field_left}), 64'({a, 16'd100}));
        end

    // Length above maximum is clamped (R3)
    for (int l = 25; l < 32; l++) begin
      a = 16'(l * 97 + 3);
      load_ctr(a, 16'd0);
      ex = ref_read(a, 24, 1'b0);
      run_op(0, 1'b0, l, 24'h0, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
      chk(rd == ex, "R3 clamp to 24 bits", 64'(rd), 64'(ex));
    end

    // Write sweep
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 32; o++)
        for (int l = 0; l <= 24; l++) begin
          logic [23:0] wd = 24'(32'hC3A596E1 ^ 32'(o*131 + l*977 + m*4099));
          a = 16'(((o*53 + l*7 + m*3) % 2048) * 32 + o);
          load_ctr(a, 16'd0);
          ref_write(a, l, m[0], wd);
          run_op(1, m[0], l, wd, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
          chk(rd == '0, "R8 write returns zero", 64'(rd), 64'd0);
          chk(lat == exp_lat(1, l, o), "R7 write latency", 64'(lat), 64'(exp_lat(1, l, o)));
          chk(en_n == exp_en(1, l, o), "R6 write access count", 64'(en_n), 64'(exp_en(1, l, o)));
          cmp_words(a, m ? "R2 msb-first write image" : "R4 write touches only field");
        end

    // Swap sweep
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 32; o += 3)
        for (int l = 1; l <= 24; l++) begin
          logic [23:0] wd = 24'(32'h1F00D5 ^ 32'(o*257 + l*31 + m*7));
          a = 16'(((o*19 + l*29 + m*11) % 2048) * 32 + o);
          load_ctr(a, 16'd0);
          ex = ref_read(a, l, m[0]);
          ref_write(a, l, m[0], wd);
          run_op(2, m[0], l, wd, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
          chk(rd == ex, "R5 swap returns old field", 64'(rd), 64'(ex));
          chk(lat == exp_lat(2, l, o), "R7 swap latency", 64'(lat), 64'(exp_lat(2, l, o)));
          cmp_words(a, "R5 swap stores new field");
        end

    // Counting walk
    load_ctr(16'h0123, 16'd20);
    ex = ref_read(16'h0123, 8, 1'b0);
    run_op(0, 1'b0, 8, 24'h0, 1'b1, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(rd == ex, "R9 first counted read", 64'(rd), 64'(ex));
    chk(field_addr == 16'h012B && field_left == 16'd12, "R9 step after first read",
        64'({field_addr, field_left}), 64'({16'h012B, 16'd12}));
    ex = ref_read(16'h012B, 8, 1'b0);
    run_op(0, 1'b0, 8, 24'h0, 1'b1, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(rd == ex, "R9 walk continues", 64'(rd), 64'(ex));
    run_op(0, 1'b0, 8, 24'h0, 1'b1, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(field_addr == 16'h013B && field_left == 16'd0, "R9 length floors at zero",
        64'({field_addr, field_left}), 64'({16'h013B, 16'd0}));
    run_op(0, 1'b0, 0, 24'h0, 1'b1, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(field_addr == 16'h013B, "R6 empty field steps by zero", 64'(field_addr), 64'h013B);

    // Load precedence over counting step
    load_ctr(16'h0200, 16'd50);
    run_op(0, 1'b0, 4, 24'h0, 1'b1, 1'b1, 16'h0777, 16'd9, rd, lat, en_n, we_n);
    chk(field_addr == 16'h0777 && field_left == 16'd9, "R10 load beats step",
        64'({field_addr, field_left}), 64'({16'h0777, 16'd9}));

    // Address wrap across the top of the space
    load_ctr(16'hFFF8, 16'd0);
    ex = ref_read(16'hFFF8, 16, 1'b0);
    run_op(0, 1'b0, 16, 24'h0, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(rd == ex, "R11 wrapped read", 64'(rd), 64'(ex));
    chk(lat == 4, "R11 wrapped read latency", 64'(lat), 64'd4);
    load_ctr(16'hFFF4, 16'd0);
    ref_write(16'hFFF4, 20, 1'b1, 24'hABCDE);
    run_op(1, 1'b1, 20, 24'hABCDE, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(lat == 6, "R11 wrapped write latency", 64'(lat), 64'd6);
    cmp_words(16'hFFF4, "R11 wrapped write image");

    // Op code 11 behaves as read; result held afterwards
    load_ctr(16'h1234, 16'd0);
    ex = ref_read(16'h1234, 13, 1'b1);
    run_op(3, 1'b1, 13, 24'hFFFFFF, 1'b0, 1'b0, 16'h0, 16'h0, rd, lat, en_n, we_n);
    chk(rd == ex && we_n == 0, "R8 op 11 reads", 64'(rd), 64'(ex));
    repeat (3) @(negedge clk);
    chk(rd_data == ex, "R8 result held while idle", 64'(rd_data), 64'(ex));
    cmp_words(16'h1234, "R8 op 11 leaves memory");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule